// File: doc/BRIEF.md
# Parallel Eight-Bin Real Fourier Transform

This block takes eight real signed samples in a single cycle and returns all eight complex frequency bins of their discrete Fourier transform. It does not use a butterfly network. Each bin has its own arithmetic path, built from that bin's closed-form equation, with the twiddle factors already folded in. A transform is started by raising the input strobe for one cycle while the eight samples are on the input bus. Back-to-back strobes are accepted, one transform per cycle.

The block has two register stages. The first captures the samples and the second captures the results. The path units between the two stages are purely combinational. Bins whose twiddles are 1, -1, j or -j use only adders. The four odd bins multiply by a fixed-point cos/sin 45 degree constant and then round the result to an integer.

Top module: `fft8_direct`

## Requirements
- R1: The eight samples on `in_samples` are stored on a rising clock edge only when `in_valid` is high. Sample n sits at bits [16n+15:16n], in two's complement. While `in_valid` is low, the stored samples and every output stay unchanged.
- R2: `out_valid` is high exactly in the cycle that follows two rising edges after the `in_valid` cycle. It is a single-cycle pulse per strobe, and consecutive strobes produce consecutive pulses that carry their own results.
- R3: A synchronous active-high `rst` clears `out_valid` and all bin outputs to zero. Between pulses of `out_valid`, the bin outputs hold the last result.
- R4: Let s_n = x_n + x_(n+4). Then bin 0 is s0+s1+s2+s3 and bin 4 is s0-s1+s2-s3. Both bins have an imaginary part of zero.
- R5: Let e = s0-s2 and f = s1-s3. Bin 2 is e - j·f and bin 6 is e + j·f, which is the exact conjugate of bin 2.
- R6: Let d_n = x_n - x_(n+4) and c = 46340/65536 (sign 0, fraction 1011010100000100). The real part of bin 1 is round(d0 + c(d1-d3)) and its imaginary part is round(-d2 - c(d1+d3)).
- R7: The real part of bin 3 is round(d0 - c(d1-d3)) and its imaginary part is round(d2 - c(d1+d3)).
- R8: Bin 5 is the exact conjugate of the rounded bin 3, and bin 7 is the exact conjugate of the rounded bin 1. The real parts are equal and the imaginary parts are negated.
- R9: The rounding takes the floor of the exact value and adds one only when the discarded fraction is strictly greater than one half. This applies to both signs, so 5792.5 gives 5792, -5792.5 gives -5793, 0.707 gives 1 and -0.707 gives -1.
- R10: Bin k's real and imaginary parts are 19-bit two's complement values at bits [19k+18:19k] of `out_re` and `out_im`. Full-scale inputs of all 32767 or all -32768 give bin 0 values of 262136 and -262144 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start strobe; samples are taken when high |
| in_samples | input | 128 | Eight packed signed 16-bit samples, sample n at [16n+15:16n] |
| out_valid | output | 1 | One-cycle pulse marking a new set of bins |
| out_re | output | 152 | Eight packed signed 19-bit real parts, bin k at [19k+18:19k] |
| out_im | output | 152 | Eight packed signed 19-bit imaginary parts, bin k at [19k+18:19k] |

## Verification
The assertions check five properties on every cycle:
- the two-edge valid latency;
- outputs holding between pulses;
- the zero state after reset;
- the conjugate pairing of bins 2/6, 5/3 and 7/1;
- the absence of overflow in every odd-bin rounding.

Only the bench's scenarios can show that the numbers are correct. It compares each bin against reference values worked out from the equations for several input patterns: impulses, full-scale constants, alternating extremes, a pseudo-random sweep, and the round-half and below-half cases.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int NPTS        = 8;
  localparam int DEF_SMP_W   = 16;
  localparam int DEF_FRAC_W  = 16;
  localparam int DEF_COS45   = 46340;
  localparam int GROWTH_BITS = 3;
endpackage

// File: rtl/fft8_capture.sv
module fft8_capture
  import fft8_pkg::*;
#(
  parameter int SMP_W = DEF_SMP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NPTS*SMP_W-1:0]   in_flat,
  output logic signed [SMP_W-1:0] bank [NPTS],
  output logic                    cap_valid
);
  always_ff @(posedge clk) begin
    if (rst) cap_valid <= 1'b0;
    else     cap_valid <= in_valid;
  end

  for (genvar n = 0; n < NPTS; n++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)           bank[n] <= '0;
      else if (in_valid) bank[n] <= in_flat[n*SMP_W +: SMP_W];
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (bank[n] == $past(in_flat[n*SMP_W +: SMP_W])));
    p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(bank[n]));
  end
endmodule

// File: rtl/fft8_even_path.sv
module fft8_even_path
  import fft8_pkg::*;
#(
  parameter int BIN   = 0,
  parameter int SMP_W = DEF_SMP_W,
  parameter int BIN_W = DEF_SMP_W + GROWTH_BITS
) (
  input  logic signed [SMP_W-1:0] smp [NPTS],
  output logic signed [BIN_W-1:0] re_o,
  output logic signed [BIN_W-1:0] im_o
);
  localparam int HALF = NPTS / 2;
  localparam int S_W  = SMP_W + 1;

  logic signed [S_W-1:0]   s [HALF];
  logic signed [BIN_W-1:0] sw [HALF];

  for (genvar n = 0; n < HALF; n++) begin : g_pair
    assign s[n]  = S_W'(smp[n]) + S_W'(smp[n+HALF]);
    assign sw[n] = BIN_W'(s[n]);
  end

  if (BIN == 0) begin : g_dc
    assign re_o = sw[0] + sw[1] + sw[2] + sw[3];
    assign im_o = '0;
  end else if (BIN == 4) begin : g_nyq
    assign re_o = sw[0] - sw[1] + sw[2] - sw[3];
    assign im_o = '0;
  end else if (BIN == 2) begin : g_quarter
    assign re_o = sw[0] - sw[2];
    assign im_o = sw[3] - sw[1];
  end else begin : g_three_quarter
    assign re_o = sw[0] - sw[2];
    assign im_o = sw[1] - sw[3];
  end
endmodule

// File: rtl/fft8_odd_path.sv
module fft8_odd_path
  import fft8_pkg::*;
#(
  parameter int BIN    = 1,
  parameter int SMP_W  = DEF_SMP_W,
  parameter int BIN_W  = DEF_SMP_W + GROWTH_BITS,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int COEF   = DEF_COS45
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SMP_W-1:0] smp [NPTS],
  output logic signed [BIN_W-1:0] re_o,
  output logic signed [BIN_W-1:0] im_o
);
  localparam int HALF  = NPTS / 2;
  localparam int D_W   = SMP_W + 1;
  localparam int ACC_W = BIN_W + FRAC_W + 2;
  localparam bit FIRST_BASE = (BIN == 1) || (BIN == 7);
  localparam bit CONJ       = (BIN == 5) || (BIN == 7);
  localparam logic [FRAC_W-1:0] HALF_LSB = {1'b1, {(FRAC_W-1){1'b0}}};

  logic signed [D_W-1:0]   d [HALF];
  logic signed [ACC_W-1:0] dw [HALF];
  logic signed [ACC_W-1:0] coef_w, cm, cp, d0_q, d2_q;
  logic signed [ACC_W-1:0] re_acc, im_acc, re_fl, im_fl, re_wide, im_wide;
  logic                    re_up, im_up;
  logic signed [BIN_W-1:0] im_base;

  for (genvar n = 0; n < HALF; n++) begin : g_diff
    assign d[n]  = D_W'(smp[n]) - D_W'(smp[n+HALF]);
    assign dw[n] = ACC_W'(d[n]);
  end

  assign coef_w = ACC_W'(COEF);
  assign cm     = (dw[1] - dw[3]) * coef_w;
  assign cp     = (dw[1] + dw[3]) * coef_w;
  assign d0_q   = dw[0] <<< FRAC_W;
  assign d2_q   = dw[2] <<< FRAC_W;

  if (FIRST_BASE) begin : g_base1
    assign re_acc = d0_q + cm;
    assign im_acc = -d2_q - cp;
  end else begin : g_base3
    assign re_acc = d0_q - cm;
    assign im_acc = d2_q - cp;
  end

  assign re_fl   = re_acc >>> FRAC_W;
  assign im_fl   = im_acc >>> FRAC_W;
  assign re_up   = re_acc[FRAC_W-1:0] > HALF_LSB;
  assign im_up   = im_acc[FRAC_W-1:0] > HALF_LSB;
  assign re_wide = re_fl + {{(ACC_W-1){1'b0}}, re_up};
  assign im_wide = im_fl + {{(ACC_W-1){1'b0}}, im_up};
  assign re_o    = re_wide[BIN_W-1:0];
  assign im_base = im_wide[BIN_W-1:0];

  if (CONJ) begin : g_conj
    assign im_o = -im_base;
  end else begin : g_direct
    assign im_o = im_base;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (re_wide == ACC_W'(re_o)) && (im_wide == ACC_W'(im_base)));
endmodule

// File: rtl/fft8_direct.sv
module fft8_direct
  import fft8_pkg::*;
#(
  parameter int SMP_W  = DEF_SMP_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int COEF   = DEF_COS45
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NPTS*SMP_W-1:0]        in_samples,
  output logic                         out_valid,
  output logic [NPTS*(SMP_W+GROWTH_BITS)-1:0] out_re,
  output logic [NPTS*(SMP_W+GROWTH_BITS)-1:0] out_im
);
  localparam int BIN_W = SMP_W + GROWTH_BITS;

  logic signed [SMP_W-1:0] bank [NPTS];
  logic                    cap_valid;
  logic signed [BIN_W-1:0] re_c [NPTS];
  logic signed [BIN_W-1:0] im_c [NPTS];
  logic signed [BIN_W-1:0] re_q [NPTS];
  logic signed [BIN_W-1:0] im_q [NPTS];

  fft8_capture #(.SMP_W(SMP_W)) u_capture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flat(in_samples),
    .bank(bank), .cap_valid(cap_valid)
  );

  for (genvar k = 0; k < NPTS; k++) begin : g_bin
    if (k % 2 == 0) begin : g_even
      fft8_even_path #(.BIN(k), .SMP_W(SMP_W), .BIN_W(BIN_W)) u_path (
        .smp(bank), .re_o(re_c[k]), .im_o(im_c[k])
      );
    end else begin : g_odd
      fft8_odd_path #(.BIN(k), .SMP_W(SMP_W), .BIN_W(BIN_W),
                      .FRAC_W(FRAC_W), .COEF(COEF)) u_path (
        .clk(clk), .rst(rst), .smp(bank), .re_o(re_c[k]), .im_o(im_c[k])
      );
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        re_q[k] <= '0;
        im_q[k] <= '0;
      end else if (cap_valid) begin
        re_q[k] <= re_c[k];
        im_q[k] <= im_c[k];
      end
    end

    assign out_re[k*BIN_W +: BIN_W] = re_q[k];
    assign out_im[k*BIN_W +: BIN_W] = im_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= cap_valid;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_valid |=> ($stable(out_re) && $stable(out_im) && !out_valid));
  p_reset_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_re == '0 && out_im == '0));
  p_conj26_r5: assert property (@(posedge clk) disable iff (rst)
    (re_q[6] == re_q[2]) && (im_q[6] == -im_q[2]));
  p_conj_r8: assert property (@(posedge clk) disable iff (rst)
    (re_q[5] == re_q[3]) && (im_q[5] == -im_q[3]) &&
    (re_q[7] == re_q[1]) && (im_q[7] == -im_q[1]));
endmodule

// File: tb/fft8_direct_test.sv
module fft8_direct_test;
  localparam int SW = 16;
  localparam int BW = 19;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [8*SW-1:0] in_samples = '0;
  logic            out_valid;
  logic [8*BW-1:0] out_re, out_im;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int er [8];
  int ei [8];
  int lfsr = 32'h1ACE5EED;

  fft8_direct uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #2.5 clk = ~clk;

  function automatic int rnd(longint f);
    longint fl = f >>> 16;
    longint fr = f & 64'd65535;
    return int'(fl + ((fr > 32768) ? 1 : 0));
  endfunction

  task automatic ref_bins(input int x [8]);
    int s0 = x[0] + x[4], s1 = x[1] + x[5], s2 = x[2] + x[6], s3 = x[3] + x[7];
    longint d0 = x[0] - x[4], d1 = x[1] - x[5], d2 = x[2] - x[6], d3 = x[3] - x[7];
    longint c = 46340;
    er[0] = s0 + s1 + s2 + s3; ei[0] = 0;
    er[4] = s0 - s1 + s2 - s3; ei[4] = 0;
    er[2] = s0 - s2;           ei[2] = s3 - s1;
    er[6] = s0 - s2;           ei[6] = s1 - s3;
    er[1] = rnd(d0 * 65536 + c * (d1 - d3));
    ei[1] = rnd(-d2 * 65536 - c * (d1 + d3));
    er[3] = rnd(d0 * 65536 - c * (d1 - d3));
    ei[3] = rnd(d2 * 65536 - c * (d1 + d3));
    er[5] = er[3]; ei[5] = -ei[3];
    er[7] = er[1]; ei[7] = -ei[1];
  endtask

  function automatic int got_re(int k);
    return int'($signed(out_re[k*BW +: BW]));
  endfunction
  function automatic int got_im(int k);
    return int'($signed(out_im[k*BW +: BW]));
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic string bin_req(int k);
    case (k)
      0, 4: return "R4";
      2, 6: return "R5";
      1:    return "R6";
      3:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_bins(string tag);
    for (int k = 0; k < 8; k++) begin
      check(bin_req(k), $sformatf("%s bin%0d re", tag, k), got_re(k), er[k]);
      check(bin_req(k), $sformatf("%s bin%0d im", tag, k), got_im(k), ei[k]);
    end
  endtask

  task automatic drive(input int x [8]);
    for (int n = 0; n < 8; n++) in_samples[n*SW +: SW] = x[n][SW-1:0];
  endtask

  task automatic run_one(input int x [8], string tag);
    @(negedge clk); drive(x); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R2", {tag, " valid after one edge"}, int'(out_valid), 0);
    @(negedge clk);
    check("R2", {tag, " valid after two edges"}, int'(out_valid), 1);
    ref_bins(x);
    check_bins(tag);
    @(negedge clk);
    check("R2", {tag, " valid pulse ends"}, int'(out_valid), 0);
    check("R3", {tag, " bin1 re held"}, got_re(1), er[1]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R3", "reset out_valid", int'(out_valid), 0);
    check("R3", "reset re zero", int'(out_re == '0), 1);
    check("R3", "reset im zero", int'(out_im == '0), 1);
  endtask

  task automatic t_impulses();
    for (int p = 0; p < 8; p++) begin
      int x [8] = '{default: 0};
      x[p] = 1000 - 300 * p;
      run_one(x, $sformatf("impulse%0d", p));
    end
  endtask

  task automatic t_full_scale();
    int xp [8] = '{default: 32767};
    int xn [8] = '{default: -32768};
    run_one(xp, "fullpos");
    check("R10", "fullpos bin0", got_re(0), 262136);
    run_one(xn, "fullneg");
    check("R10", "fullneg bin0", got_re(0), -262144);
  endtask

  task automatic t_alternating();
    int x [8] = '{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768};
    int y [8] = '{32767, 32767, -32768, -32768, -32768, -32768, 32767, 32767};
    run_one(x, "alt");
    check("R4", "alt bin4", got_re(4), 4 * 65535);
    run_one(y, "pairs");
  endtask

  task automatic t_rounding();
    int a [8] = '{0, 8192, 0, 0, 0, 0, 0, 0};
    int b [8] = '{0, 1, 0, 0, 0, 0, 0, 0};
    int c [8] = '{0, 3, 0, 0, 0, 0, 0, 0};
    run_one(a, "half");
    check("R9", "half positive truncates", got_re(1), 5792);
    check("R9", "half negative floors", got_im(1), -5793);
    check("R8", "bin7 im conj of half", got_im(7), 5793);
    run_one(b, "unit");
    check("R9", "0.707 rounds up", got_re(1), 1);
    check("R9", "-0.707 to -1", got_im(1), -1);
    run_one(c, "three");
    check("R9", "2.12 truncates", got_re(1), 2);
    check("R9", "-2.12 to -3 plus 1", got_im(1), -2);
  endtask

  task automatic t_random();
    for (int v = 0; v < 24; v++) begin
      int x [8];
      for (int n = 0; n < 8; n++) begin
        lfsr ^= lfsr << 13; lfsr ^= lfsr >>> 17; lfsr ^= lfsr << 5;
        x[n] = int'($signed(lfsr[15:0]));
      end
      run_one(x, $sformatf("rand%0d", v));
    end
  endtask

  task automatic t_hold();
    int x [8] = '{5, -7, 11, 13, -17, 19, 23, -29};
    int z [8] = '{-30000, 20000, 1, 2, 3, 4, 5, 6};
    logic [8*BW-1:0] hr, hi;
    run_one(x, "holdbase");
    hr = out_re; hi = out_im;
    @(negedge clk); drive(z);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R1", "samples ignored, valid low", int'(out_valid), 0);
      check("R3", "re held while idle", int'(out_re == hr), 1);
      check("R1", "im held while idle", int'(out_im == hi), 1);
    end
    run_one(z, "afterhold");
  endtask

  task automatic t_back_to_back();
    int a [8] = '{100, 200, 300, 400, 500, 600, 700, 800};
    int b [8] = '{-9, 8, -7, 6, -5, 4, -3, 2};
    @(negedge clk); drive(a); in_valid = 1'b1;
    @(negedge clk); drive(b);
    @(negedge clk); in_valid = 1'b0;
    check("R2", "b2b first pulse", int'(out_valid), 1);
    ref_bins(a); check_bins("b2b first");
    @(negedge clk);
    check("R2", "b2b second pulse", int'(out_valid), 1);
    ref_bins(b); check_bins("b2b second");
    @(negedge clk);
    check("R2", "b2b pulse ends", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_impulses();
    t_full_scale();
    t_alternating();
    t_rounding();
    t_hold();
    t_back_to_back();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule